// File: doc/BRIEF.md
# Accumulator Datapath with Sixteen-Entry Register File

This block is the execute datapath of a small accumulator-style processor whose word width is set by a parameter. Sixteen registers are reachable through a 4-bit index. Index 0 is the implicit working register (the accumulator). Index 1 is the status register, index 2 the stack pointer and index 3 the program counter. Indices 4 to 15 are general purpose. Almost every operation reads the accumulator, the register named by the 4-bit operand, or both, and writes its result back into the accumulator.

A controller presents an operation code and a 4-bit operand and raises the strobe for one cycle. The result is registered on that rising clock edge. The two compares write nothing but the comparison bit, which is bit 0 of the status register. Shift distances are taken from the indexed register. A separate read index brings any register out combinationally, so a controller or debugger can observe the register state.

The word width must be a power of two of at least 8. Reset is asynchronous and active low. There are no states beyond the register contents: each strobed operation completes in the cycle it is presented, and there are no transitions to name.

Top module: `acc_datapath`

## Requirements
- R1: While reset is asserted, and after it is released, every one of the sixteen registers reads zero on `rd_data`, and both `acc_out` and `cmp_flag` are zero.
- R2: `rd_data` combinationally returns the register selected by `rd_idx`. Index 0 is the accumulator, 1 the status register, 2 the stack pointer, 3 the program counter and 4 to 15 general purpose. Operation codes on `op_sel`: 1 set, 2 read, 3 copy, 4 add, 5 subtract, 6 and, 7 or, 8 xor, 9 not, 10 shift left, 11 shift right, 12 equal, 13 less-than.
- R3: Set (1) loads `operand`, zero-extended, into the accumulator, and the value is visible after the strobed edge.
- R4: Read (2) copies register[operand] into the accumulator. Copy (3) writes the accumulator into register[operand] and leaves the accumulator unchanged. A copy to index 0 changes nothing.
- R5: Add (4) and subtract (5) write accumulator plus, or minus, register[operand] into the accumulator, modulo 2^WIDTH.
- R6: And (6), or (7) and xor (8) combine the accumulator bitwise with register[operand]. Not (9) writes the bitwise inverse of register[operand], not of the accumulator.
- R7: Shift left (10) and shift right (11) move the accumulator by the unsigned value held in register[operand], filling with zeros. A distance of WIDTH or more gives zero.
- R8: Equal (12) and less-than (13, unsigned) set status bit 0 to 1 when the accumulator is equal to, or below, register[operand], and clear it otherwise. The accumulator, the other status bits and all other registers are unchanged.
- R9: `cmp_flag` equals status bit 0. A copy into index 1 stores only the low 8 bits of the accumulator, so any status bits above bit 7 read zero.
- R10: With `op_valid` low, or with `op_sel` equal to 0, 14 or 15, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe: execute `op_sel` on this edge |
| op_sel | input | 4 | Operation code |
| operand | input | 4 | Register index or 4-bit immediate |
| rd_idx | input | 4 | Index for the observation read port |
| acc_out | output | WIDTH | Accumulator contents |
| cmp_flag | output | 1 | Comparison bit (status bit 0) |
| rd_data | output | WIDTH | Contents of register `rd_idx` |

## Verification
The bench crosses sixteen operand patterns with themselves for every arithmetic, logic, shift and compare operation. The pattern set includes equal pairs, the all-ones and zero words, and shift distances of 7, 8, 9 and 255. A design that saturated or wrapped shift distances above the width would give nonzero shifted results. A design that compared as signed would get the 0x80 and 0xFF pairs wrong. A design that inverted the accumulator in not would disagree on every unequal pair. The bench also writes the status register with a copy and then runs compares, to catch a compare that overwrites the whole status word instead of bit 0. It sweeps the whole register file after reserved codes, a strobe-low cycle and a copy into index 0, so that any stray write shows up on the read port.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int NUM_REGS    = 16;
    localparam int IDX_W       = $clog2(NUM_REGS);
    localparam int OP_W        = 4;
    localparam int STATUS_BITS = 8;
    localparam int CMP_BIT     = 0;

    localparam logic [IDX_W-1:0] IDX_ACC  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_STAT = 4'd1;
    localparam logic [IDX_W-1:0] IDX_SP   = 4'd2;
    localparam logic [IDX_W-1:0] IDX_PC   = 4'd3;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 4'h0,
        OP_SET   = 4'h1,
        OP_READ  = 4'h2,
        OP_COPY  = 4'h3,
        OP_ADD   = 4'h4,
        OP_SUB   = 4'h5,
        OP_AND   = 4'h6,
        OP_OR    = 4'h7,
        OP_XOR   = 4'h8,
        OP_NOT   = 4'h9,
        OP_SHL   = 4'hA,
        OP_SHR   = 4'hB,
        OP_EQ    = 4'hC,
        OP_LT    = 4'hD,
        OP_RSV_E = 4'hE,
        OP_RSV_F = 4'hF
    } op_e;

endpackage

// File: rtl/acc_shifter.sv
module acc_shifter #(
    parameter int WIDTH = 8,
    parameter bit LEFT  = 1'b1
) (
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] cnt,
    output logic [WIDTH-1:0] dout
);
    localparam int LOG = $clog2(WIDTH);

    logic [WIDTH-1:0] stg [LOG+1];
    logic             ovf;

    assign stg[0] = din;

    generate
        for (genvar s = 0; s < LOG; s++) begin : g_stage
            if (LEFT) begin : g_left
                assign stg[s+1] = cnt[s] ? (stg[s] << (1 << s)) : stg[s];
            end else begin : g_right
                assign stg[s+1] = cnt[s] ? (stg[s] >> (1 << s)) : stg[s];
            end
        end
    endgenerate

    // any count bit at or above LOG means a distance of WIDTH or more
    assign ovf  = |cnt[WIDTH-1:LOG];
    assign dout = ovf ? '0 : stg[LOG];

    always_comb begin
        // R7
        if (cnt == '0) begin
            zero_shift_chk: assert (dout == din);
        end
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             valid,
    input  op_e              op,
    input  logic [IDX_W-1:0] imm,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] opnd,
    output logic             acc_we,
    output logic [WIDTH-1:0] acc_wd,
    output logic             idx_we,
    output logic             flg_we,
    output logic             flg_val
);
    logic [WIDTH-1:0] shl_res;
    logic [WIDTH-1:0] shr_res;

    acc_shifter #(.WIDTH(WIDTH), .LEFT(1'b1)) u_shl (
        .din  (acc),
        .cnt  (opnd),
        .dout (shl_res)
    );

    acc_shifter #(.WIDTH(WIDTH), .LEFT(1'b0)) u_shr (
        .din  (acc),
        .cnt  (opnd),
        .dout (shr_res)
    );

    always_comb begin
        acc_we  = 1'b0;
        acc_wd  = acc;
        idx_we  = 1'b0;
        flg_we  = 1'b0;
        flg_val = 1'b0;
        if (valid) begin
            unique case (op)
                OP_SET:  begin acc_we = 1'b1; acc_wd = WIDTH'(imm);  end
                OP_READ: begin acc_we = 1'b1; acc_wd = opnd;         end
                OP_COPY: begin idx_we = 1'b1;                        end
                OP_ADD:  begin acc_we = 1'b1; acc_wd = acc + opnd;   end
                OP_SUB:  begin acc_we = 1'b1; acc_wd = acc - opnd;   end
                OP_AND:  begin acc_we = 1'b1; acc_wd = acc & opnd;   end
                OP_OR:   begin acc_we = 1'b1; acc_wd = acc | opnd;   end
                OP_XOR:  begin acc_we = 1'b1; acc_wd = acc ^ opnd;   end
                OP_NOT:  begin acc_we = 1'b1; acc_wd = ~opnd;        end
                OP_SHL:  begin acc_we = 1'b1; acc_wd = shl_res;      end
                OP_SHR:  begin acc_we = 1'b1; acc_wd = shr_res;      end
                OP_EQ:   begin flg_we = 1'b1; flg_val = (acc == opnd); end
                OP_LT:   begin flg_we = 1'b1; flg_val = (acc <  opnd); end
                OP_NOP, OP_RSV_E, OP_RSV_F: begin end
            endcase
        end
    end

endmodule

// File: rtl/acc_regfile.sv
module acc_regfile
    import acc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_we,
    input  logic [WIDTH-1:0] acc_wd,
    input  logic             idx_we,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] idx_wd,
    input  logic             flg_we,
    input  logic             flg_val,
    input  logic [IDX_W-1:0] op_idx,
    output logic [WIDTH-1:0] opnd,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] acc,
    output logic             flag
);
    logic [WIDTH-1:0] regs [NUM_REGS];
    logic [WIDTH-1:0] stat_mask;

    always_comb begin
        stat_mask = '0;
        stat_mask[STATUS_BITS-1:0] = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs[i] <= '0;
            end
        end else begin
            if (acc_we) begin
                regs[IDX_ACC] <= acc_wd;
            end
            if (idx_we) begin
                if (wr_idx == IDX_STAT) begin
                    regs[IDX_STAT] <= idx_wd & stat_mask;
                end else if (wr_idx != IDX_ACC) begin
                    regs[wr_idx] <= idx_wd;
                end
            end
            if (flg_we) begin
                regs[IDX_STAT][CMP_BIT] <= flg_val;
            end
        end
    end

    assign opnd    = regs[op_idx];
    assign rd_data = regs[rd_idx];
    assign acc     = regs[IDX_ACC];
    assign flag    = regs[IDX_STAT][CMP_BIT];

    // R10
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_we, idx_we, flg_we}));

    generate
        if (WIDTH > STATUS_BITS) begin : g_stat_hi
            // R9
            stat_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
                regs[IDX_STAT][WIDTH-1:STATUS_BITS] == '0);
        end
    endgenerate

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
    import acc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [3:0]       op_sel,
    input  logic [3:0]       operand,
    input  logic [3:0]       rd_idx,
    output logic [WIDTH-1:0] acc_out,
    output logic             cmp_flag,
    output logic [WIDTH-1:0] rd_data
);
    op_e              op;
    logic [WIDTH-1:0] acc;
    logic [WIDTH-1:0] opnd;
    logic             acc_we;
    logic [WIDTH-1:0] acc_wd;
    logic             idx_we;
    logic             flg_we;
    logic             flg_val;

    assign op = op_e'(op_sel);

    acc_alu #(.WIDTH(WIDTH)) u_alu (
        .valid   (op_valid),
        .op      (op),
        .imm     (operand),
        .acc     (acc),
        .opnd    (opnd),
        .acc_we  (acc_we),
        .acc_wd  (acc_wd),
        .idx_we  (idx_we),
        .flg_we  (flg_we),
        .flg_val (flg_val)
    );

    acc_regfile #(.WIDTH(WIDTH)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_we  (acc_we),
        .acc_wd  (acc_wd),
        .idx_we  (idx_we),
        .wr_idx  (operand),
        .idx_wd  (acc),
        .flg_we  (flg_we),
        .flg_val (flg_val),
        .op_idx  (operand),
        .opnd    (opnd),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .acc     (acc),
        .flag    (cmp_flag)
    );

    assign acc_out = acc;

    // R3
    set_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'h1) |=> (acc_out == WIDTH'($past(operand))));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_sel == 4'h0 || op_sel == 4'hE || op_sel == 4'hF)
        |=> ($stable(acc_out) && $stable(cmp_flag)));

    // R8
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == 4'hC || op_sel == 4'hD)) |=> $stable(acc_out));

    // R4
    copy_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 4'h3) |=> $stable(acc_out));

endmodule

// File: tb/acc_datapath_test.sv
module acc_datapath_test;
    localparam int W          = 8;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [3:0]   op_sel = 4'h0;
    logic [3:0]   operand = 4'h0;
    logic [3:0]   rd_idx = 4'h0;
    logic [W-1:0] acc_out;
    logic         cmp_flag;
    logic [W-1:0] rd_data;

    logic [W-1:0] m [16];
    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_datapath #(.WIDTH(W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_sel   (op_sel),
        .operand  (operand),
        .rd_idx   (rd_idx),
        .acc_out  (acc_out),
        .cmp_flag (cmp_flag),
        .rd_data  (rd_data)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'h1: return "R3";
            4'h2, 4'h3: return "R4";
            4'h4, 4'h5: return "R5";
            4'h6, 4'h7, 4'h8, 4'h9: return "R6";
            4'hA, 4'hB: return "R7";
            4'hC, 4'hD: return "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic model(input logic [3:0] op, input logic [3:0] x);
        logic [W-1:0] a, b;
        a = m[0];
        b = m[x];
        case (op)
            4'h1: m[0] = W'(x);
            4'h2: m[0] = b;
            4'h3: begin
                if (x == 4'd1) m[1] = a & W'(8'hFF);
                else if (x != 4'd0) m[x] = a;
            end
            4'h4: m[0] = a + b;
            4'h5: m[0] = a - b;
            4'h6: m[0] = a & b;
            4'h7: m[0] = a | b;
            4'h8: m[0] = a ^ b;
            4'h9: m[0] = ~b;
            4'hA: m[0] = (int'(b) >= W) ? '0 : (a << b);
            4'hB: m[0] = (int'(b) >= W) ? '0 : (a >> b);
            4'hC: m[1][0] = (a == b);
            4'hD: m[1][0] = (a < b);
            default: ;
        endcase
    endtask

    task automatic issue(input logic [3:0] op, input logic [3:0] x, input string tag);
        @(negedge clk);
        op_valid = 1'b1;
        op_sel   = op;
        operand  = x;
        @(negedge clk);
        op_valid = 1'b0;
        op_sel   = 4'h0;
        rd_idx   = x;
        model(op, x);
        #1;
        check({tag, " acc"}, acc_out, m[0]);
        check({tag, " flag"}, W'(cmp_flag), W'(m[1][0]));
        check({tag, " rd"}, rd_data, m[x]);
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #1;
            check(tag, rd_data, m[i]);
        end
    endtask

    task automatic load_val(input logic [3:0] idx, input logic [W-1:0] v, input string tag);
        issue(4'h1, v[3:0], tag);
        issue(4'h3, 4'd14, tag);
        issue(4'h1, v[7:4], tag);
        issue(4'hA, 4'd15, tag);
        issue(4'h7, 4'd14, tag);
        issue(4'h3, idx, tag);
    endtask

    function automatic logic [W-1:0] pat(input int i);
        case (i)
            0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h03;
            4: return 8'h05;  5: return 8'h07;  6: return 8'h08;  7: return 8'h09;
            8: return 8'h0F;  9: return 8'h10; 10: return 8'h55; 11: return 8'h7F;
            12: return 8'h80; 13: return 8'hAA; 14: return 8'hFE; default: return 8'hFF;
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 190000);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state, held and after release
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");
        check("R1 acc", acc_out, '0);
        check("R1 flag", W'(cmp_flag), '0);

        // R3: every immediate
        for (int i = 0; i < 16; i++) issue(4'h1, 4'(i), "R3");

        // R2: index map through the read port
        issue(4'h1, 4'd5, "R2");  issue(4'h3, 4'd2, "R2");
        issue(4'h1, 4'd9, "R2");  issue(4'h3, 4'd3, "R2");
        issue(4'h1, 4'd6, "R2");  issue(4'h3, 4'd4, "R2");
        issue(4'h1, 4'd3, "R2");  issue(4'h3, 4'd13, "R2");
        check_all("R2 map");

        // R4: copy to index 0 changes nothing
        issue(4'h1, 4'd7, "R4");
        issue(4'h3, 4'd0, "R4");
        check_all("R4 copy idx0");

        // scratch shift distance of 4 in R15
        issue(4'h1, 4'd4, "R4");
        issue(4'h3, 4'd15, "R4");

        // R9: status written by copy, then compares touch only bit 0
        load_val(4'd4, 8'hFE, "R9");
        issue(4'h2, 4'd4, "R9");
        issue(4'h3, 4'd1, "R9");
        issue(4'hC, 4'd4, "R8");
        check_all("R8 eq keeps status");
        issue(4'hD, 4'd4, "R8");
        check_all("R8 lt keeps status");
        issue(4'h1, 4'd3, "R9");
        issue(4'h3, 4'd1, "R9");

        // R10: strobe low and reserved codes
        @(negedge clk);
        op_sel = 4'h1; operand = 4'hF; op_valid = 1'b0;
        @(negedge clk);
        op_sel = 4'h0;
        check_all("R10 strobe low");
        issue(4'h0, 4'd4, "R10");
        issue(4'hE, 4'd4, "R10");
        issue(4'hF, 4'd5, "R10");
        check_all("R10 reserved");

        // R5..R8: operand pattern cross product
        for (int ia = 0; ia < 16; ia++) begin
            load_val(4'd6, pat(ia), "R4");
            for (int ib = 0; ib < 16; ib++) begin
                load_val(4'd5, pat(ib), "R4");
                for (int op = 4; op <= 13; op++) begin
                    issue(4'h2, 4'd6, "R4");
                    issue(4'(op), 4'd5, tag_of(4'(op)));
                end
            end
        end
        check_all("R8 final sweep");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule